// File: doc/BRIEF.md
# Interleaved YCbCr Raster Timing Generator

This block builds the complete line and field timing for an 8-bit interleaved YCbCr byte stream on a 27 MHz byte clock. One mode input picks the 525-line or the 625-line raster. Horizontal clock and line counters drive the field flag (F) and the vertical blanking flag (V). The block places four-byte timing reference codes at the edges of every line: the end-of-active code opens the line and the start-of-active code closes the blanking interval. Between those codes it passes active video bytes from a simple pixel stream. It fills blanking with the neutral chroma and black luma values.

Alongside the embedded codes, the block drives separate horizontal (HD) and vertical (VD) sync pulses. In standard mode, HD spans the whole blanking interval and VD follows the V flag. In sync-through mode, HD is a fixed-width pulse and VD lasts a fixed number of half-lines. The VD pulse of the second field starts half a line later relative to HD. Embedded code insertion can be switched off, which leaves only the discrete sync pulses.

Per mode, the line holds 2*(ACTIVE_PIX+BLANK_x) clocks (1716 for 525 lines and 1728 for 625 lines at default parameters). Every byte output, HD and VD is registered, so each reflects the raster position of the previous clock.

Top module: `ycc_raster_gen`

## Requirements
- R1: A line lasts 2*(ACTIVE_PIX+BLANK_525) clocks in 525-line mode and 2*(ACTIVE_PIX+BLANK_625) clocks in 625-line mode. A frame holds 525 or 625 lines, and the line after the last one is line 1 at clock 0.
- R2: A synchronous reset puts the raster at line 1, clock 0. While reset is held, dataOut is 0x10 and hdOut and vdOut are low.
- R3: Within a line, clocks 0-3 carry the end-of-active code and the last four blanking clocks (2*BLANK-4 to 2*BLANK-1) carry the start-of-active code. Active video fills clocks 2*BLANK onward. Every output shows the position of the previous clock.
- R4: Each reference code is the bytes 0xFF, 0x00, 0x00, XY with XY = {1, F, V, H, V^H, F^H, F^V, F^V^H} (bit 7 first). H is 1 in the end-of-active code and 0 in the start-of-active code.
- R5: In 525-line mode, F=1 on lines 1-3 and 266-525 and F=0 on lines 4-265. V=1 on lines 1-9 and 264-272.
- R6: In 625-line mode, F=0 on lines 1-312 and F=1 on lines 313-625. V=1 on lines 1-22, 311-335 and 624-625.
- R7: vidTake is high exactly on the 2*ACTIVE_PIX active clocks of each line, and the vidData byte of such a clock appears on dataOut one clock later (order Cb, Y, Cr, Y).
- R8: Blanking clocks outside the codes output 0x80 at even clock offsets and 0x10 at odd ones.
- R9: With embedEn low, the code positions carry the blanking bytes of R8 instead of the codes.
- R10: In standard mode (stdSync=1), hdOut is high from the first code byte of a line through the last start-of-active byte, which is 2*BLANK clocks, and vdOut equals the V flag of the line.
- R11: In sync-through mode (stdSync=0), hdOut is high for HD_THRU_CLKS clocks from clock 0 of each line.
- R12: In sync-through mode, vdOut for the first field starts at line 1 clock 0. For the second field it starts at clock LINE/2 of line 263 (525-line mode) or line 313 (625-line mode).
- R13: The sync-through vdOut lasts 6 half-lines. In 625-line mode with vdShort=1 it lasts 5 half-lines; in 525-line mode vdShort has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| sys625 | input | 1 | 1 selects the 625-line raster, 0 the 525-line raster |
| stdSync | input | 1 | 1 selects standard HD/VD, 0 selects sync-through HD/VD |
| embedEn | input | 1 | 1 inserts the embedded reference codes |
| vdShort | input | 1 | Selects the 2.5-line sync-through VD in 625-line mode |
| vidData | input | 8 | Active video byte, consumed when vidTake is high |
| vidTake | output | 1 | Current clock consumes vidData |
| dataOut | output | 8 | Multiplexed output byte stream |
| hdOut | output | 1 | Horizontal sync pulse, active high |
| vdOut | output | 1 | Vertical sync pulse, active high |

## Verification
The assertions assume that the four mode inputs change only while reset is held. They also assume that active video never contains the bytes 0x00 or 0xFF, so that a 0xFF 0x00 0x00 run on dataOut can only be a reference code. The stimulus sets the mode inputs during a reset phase before each run. It draws vidData from a sequence confined to 0x01-0xFE, changed on every clock. Each run covers a whole frame in its mode, so both field transitions and both VD starts occur.

// File: rtl/ycc_raster_pkg.sv
package ycc_raster_pkg;

  typedef logic [9:0] lineNum_t;

  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic       inCode;    // current clock is one of the 8 code bytes
    logic [1:0] codeIdx;   // byte index inside the code
    logic       codeH;     // 1 in the end-of-active code
    logic       fBit;
    logic       vBit;
    logic       inActive;  // active video clock
    logic       lumaSlot;  // odd clock offset carries luma
  } tgStrobe_t;

  // 525-line flag boundaries (first line of each new value)
  localparam lineNum_t L525_LAST     = 10'd525;
  localparam lineNum_t L525_F_CLR    = 10'd4;
  localparam lineNum_t L525_F_SET    = 10'd266;
  localparam lineNum_t L525_V_CLR1   = 10'd10;
  localparam lineNum_t L525_V_SET2   = 10'd264;
  localparam lineNum_t L525_V_CLR2   = 10'd273;
  localparam lineNum_t L525_VD2_LINE = 10'd263;

  // 625-line flag boundaries
  localparam lineNum_t L625_LAST     = 10'd625;
  localparam lineNum_t L625_F_SET    = 10'd313;
  localparam lineNum_t L625_V_CLR1   = 10'd23;
  localparam lineNum_t L625_V_SET2   = 10'd311;
  localparam lineNum_t L625_V_CLR2   = 10'd336;
  localparam lineNum_t L625_V_SET3   = 10'd624;
  localparam lineNum_t L625_VD2_LINE = 10'd313;

  localparam lineNum_t LINE_FIRST    = 10'd1;

  localparam logic [7:0] BLANK_C = 8'h80;
  localparam logic [7:0] BLANK_Y = 8'h10;
  localparam logic [7:0] CODE_HI = 8'hFF;
  localparam logic [7:0] CODE_LO = 8'h00;

  // Protected flag word of a timing reference code
  function automatic logic [7:0] xyWord(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/ycc_raster_ctrl.sv
module ycc_raster_ctrl
  import ycc_raster_pkg::*;
#(
  parameter int ACTIVE_PIX   = 720,
  parameter int BLANK_525    = 138,
  parameter int BLANK_625    = 144,
  parameter int HD_THRU_CLKS = 128
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sys625,
  input  logic      stdSync,
  input  logic      vdShort,
  output tgStrobe_t strobe,
  output logic      vidTake,
  output logic      hdOut,
  output logic      vdOut
);

  localparam int LINE_525 = 2 * (ACTIVE_PIX + BLANK_525);
  localparam int LINE_625 = 2 * (ACTIVE_PIX + BLANK_625);
  localparam int MAX_LINE = (LINE_625 > LINE_525) ? LINE_625 : LINE_525;
  localparam int HW       = $clog2(MAX_LINE);

  localparam logic [HW-1:0] LAST_525 = HW'(LINE_525 - 1);
  localparam logic [HW-1:0] LAST_625 = HW'(LINE_625 - 1);
  localparam logic [HW-1:0] HALF_525 = HW'(LINE_525 / 2);
  localparam logic [HW-1:0] HALF_625 = HW'(LINE_625 / 2);
  localparam logic [HW-1:0] BLK_525  = HW'(2 * BLANK_525);
  localparam logic [HW-1:0] BLK_625  = HW'(2 * BLANK_625);
  localparam logic [HW-1:0] HD_THRU  = HW'(HD_THRU_CLKS);
  localparam logic [HW-1:0] CODE_LEN = HW'(4);
  localparam logic [HW-1:0] H_ZERO   = '0;

  localparam logic [2:0] VD_HALVES_LONG  = 3'd6;
  localparam logic [2:0] VD_HALVES_SHORT = 3'd5;

  logic [HW-1:0] hCnt;
  lineNum_t      lineNo;

  logic [HW-1:0] hLast, hHalf, blkEnd, savBase, savOff;
  lineNum_t      lineLast, vd2Line;
  logic          isEav, isSav;
  logic          fBit, vBit;

  // Mode-dependent limits
  always_comb begin
    hLast    = sys625 ? LAST_625 : LAST_525;
    hHalf    = sys625 ? HALF_625 : HALF_525;
    blkEnd   = sys625 ? BLK_625  : BLK_525;
    lineLast = sys625 ? L625_LAST : L525_LAST;
    vd2Line  = sys625 ? L625_VD2_LINE : L525_VD2_LINE;
  end

  // Raster position counters
  always_ff @(posedge clk) begin
    if (rst) begin
      hCnt   <= '0;
      lineNo <= LINE_FIRST;
    end else if (hCnt == hLast) begin
      hCnt   <= '0;
      lineNo <= (lineNo == lineLast) ? LINE_FIRST : lineNo + 10'd1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  // Field and vertical blanking flags
  always_comb begin
    if (sys625) begin
      fBit = (lineNo >= L625_F_SET);
      vBit = (lineNo < L625_V_CLR1) ||
             ((lineNo >= L625_V_SET2) && (lineNo < L625_V_CLR2)) ||
             (lineNo >= L625_V_SET3);
    end else begin
      fBit = (lineNo < L525_F_CLR) || (lineNo >= L525_F_SET);
      vBit = (lineNo < L525_V_CLR1) ||
             ((lineNo >= L525_V_SET2) && (lineNo < L525_V_CLR2));
    end
  end

  // Horizontal regions
  always_comb begin
    savBase = blkEnd - CODE_LEN;
    savOff  = hCnt - savBase;
    isEav   = (hCnt < CODE_LEN);
    isSav   = (hCnt >= savBase) && (hCnt < blkEnd);
    vidTake = (hCnt >= blkEnd);

    strobe.inCode   = isEav || isSav;
    strobe.codeIdx  = isEav ? hCnt[1:0] : savOff[1:0];
    strobe.codeH    = isEav;
    strobe.fBit     = fBit;
    strobe.vBit     = vBit;
    strobe.inActive = vidTake;
    strobe.lumaSlot = hCnt[0];
  end

  // Sync-through VD: counts half-lines from its start point
  logic       vdBusy;
  logic [2:0] vdCnt;
  logic [2:0] vdHalves;
  logic       halfTick, startTick, vdThruNow, hdNow, vdNow;

  always_comb begin
    vdHalves  = (sys625 && vdShort) ? VD_HALVES_SHORT : VD_HALVES_LONG;
    halfTick  = (hCnt == H_ZERO) || (hCnt == hHalf);
    startTick = ((lineNo == LINE_FIRST) && (hCnt == H_ZERO)) ||
                ((lineNo == vd2Line) && (hCnt == hHalf));
    vdThruNow = startTick || (vdBusy && !(halfTick && (vdCnt == vdHalves)));
    hdNow     = stdSync ? (hCnt < blkEnd) : (hCnt < HD_THRU);
    vdNow     = stdSync ? vBit : vdThruNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vdBusy <= 1'b0;
      vdCnt  <= '0;
    end else if (startTick) begin
      vdBusy <= 1'b1;
      vdCnt  <= 3'd1;
    end else if (halfTick && vdBusy) begin
      if (vdCnt == vdHalves) vdBusy <= 1'b0;
      else                   vdCnt  <= vdCnt + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdOut <= 1'b0;
      vdOut <= 1'b0;
    end else begin
      hdOut <= hdNow;
      vdOut <= vdNow;
    end
  end

  // Run length of the HD pulse, used only by the checks below
  logic [HW-1:0] hdLen;
  always_ff @(posedge clk) begin
    if (rst) hdLen <= '0;
    else     hdLen <= hdOut ? hdLen + 1'b1 : '0;
  end

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hCnt == hLast && lineNo == lineLast) |=> (hCnt == H_ZERO && lineNo == LINE_FIRST)); // R1

  AST_FIELD_AT_LINE_START: assert property (@(posedge clk) disable iff (rst)
    !$stable(fBit) |-> (hCnt == H_ZERO)); // R5

  AST_HD_STD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(hdOut) && stdSync) |-> (hdLen == blkEnd)); // R10

  AST_HD_THRU_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(hdOut) && !stdSync) |-> (hdLen == HD_THRU)); // R11

endmodule

// File: rtl/ycc_raster_dp.sv
module ycc_raster_dp
  import ycc_raster_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      embedEn,
  input  tgStrobe_t strobe,
  input  logic [7:0] vidData,
  output logic [7:0] dataOut
);

  logic [7:0] codeByte;
  logic [7:0] blankByte;

  always_comb begin
    case (strobe.codeIdx)
      2'd0:    codeByte = CODE_HI;
      2'd3:    codeByte = xyWord(strobe.fBit, strobe.vBit, strobe.codeH);
      default: codeByte = CODE_LO;
    endcase
    blankByte = strobe.lumaSlot ? BLANK_Y : BLANK_C;
  end

  always_ff @(posedge clk) begin
    if (rst)                            dataOut <= BLANK_Y;
    else if (strobe.inCode && embedEn)  dataOut <= codeByte;
    else if (strobe.inActive)           dataOut <= vidData;
    else                                dataOut <= blankByte;
  end

  AST_XY_PROTECTED: assert property (@(posedge clk) disable iff (rst)
    ($past(dataOut, 3) == CODE_HI && $past(dataOut, 2) == CODE_LO && $past(dataOut) == CODE_LO)
      |-> (dataOut[7] && dataOut[3] == (dataOut[5] ^ dataOut[4]) &&
           dataOut[2] == (dataOut[6] ^ dataOut[4]) && dataOut[1] == (dataOut[6] ^ dataOut[5]) &&
           dataOut[0] == (dataOut[6] ^ dataOut[5] ^ dataOut[4]))); // R4

  AST_NO_CODE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(!embedEn && strobe.inCode) |-> (dataOut == BLANK_C || dataOut == BLANK_Y)); // R9

endmodule

// File: rtl/ycc_raster_gen.sv
module ycc_raster_gen
  import ycc_raster_pkg::*;
#(
  parameter int ACTIVE_PIX   = 720,
  parameter int BLANK_525    = 138,
  parameter int BLANK_625    = 144,
  parameter int HD_THRU_CLKS = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sys625,
  input  logic       stdSync,
  input  logic       embedEn,
  input  logic       vdShort,
  input  logic [7:0] vidData,
  output logic       vidTake,
  output logic [7:0] dataOut,
  output logic       hdOut,
  output logic       vdOut
);

  tgStrobe_t strobe;

  ycc_raster_ctrl #(
    .ACTIVE_PIX  (ACTIVE_PIX),
    .BLANK_525   (BLANK_525),
    .BLANK_625   (BLANK_625),
    .HD_THRU_CLKS(HD_THRU_CLKS)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .sys625 (sys625),
    .stdSync(stdSync),
    .vdShort(vdShort),
    .strobe (strobe),
    .vidTake(vidTake),
    .hdOut  (hdOut),
    .vdOut  (vdOut)
  );

  ycc_raster_dp uDp (
    .clk    (clk),
    .rst    (rst),
    .embedEn(embedEn),
    .strobe (strobe),
    .vidData(vidData),
    .dataOut(dataOut)
  );

endmodule

// File: tb/ycc_raster_gen_test.sv
`timescale 1ns/1ps
module ycc_raster_gen_test;

  localparam int A    = 8;
  localparam int B525 = 12;
  localparam int B625 = 14;
  localparam int HDT  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys625 = 1'b0, stdSync = 1'b1, embedEn = 1'b1, vdShort = 1'b0;
  logic [7:0] vidData = 8'h01;
  logic vidTake, hdOut, vdOut;
  logic [7:0] dataOut;

  always #4 clk = ~clk;

  ycc_raster_gen #(.ACTIVE_PIX(A), .BLANK_525(B525), .BLANK_625(B625), .HD_THRU_CLKS(HDT)) uut (
    .clk(clk), .rst(rst), .sys625(sys625), .stdSync(stdSync), .embedEn(embedEn),
    .vdShort(vdShort), .vidData(vidData), .vidTake(vidTake), .dataOut(dataOut),
    .hdOut(hdOut), .vdOut(vdOut));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int blkOf(input logic s); return 2 * (s ? B625 : B525); endfunction
  function automatic int lineOf(input logic s); return 2 * (A + (s ? B625 : B525)); endfunction

  function automatic bit fOf(input logic s, input int ln);
    if (s) return ln >= 313;
    return (ln <= 3) || (ln >= 266);
  endfunction

  function automatic bit vOf(input logic s, input int ln);
    if (s) return (ln <= 22) || (ln >= 311 && ln <= 335) || (ln >= 624);
    return (ln <= 9) || (ln >= 264 && ln <= 272);
  endfunction

  // Behavioural reference state
  int mH = 0, mLine = 1;
  bit live = 0;
  int eD, eHd, eVd;
  string tD, tHd, tVd;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mH = 0; mLine = 1; live = 0;
    end else begin
      int blk, lc, idx, hl, w, fs;
      bit isCode, hb, f, v, inWin;
      blk = blkOf(sys625); lc = lineOf(sys625);
      f = fOf(sys625, mLine); v = vOf(sys625, mLine);
      isCode = 0; idx = 0; hb = 0;
      if (mH < 4) begin isCode = 1; idx = mH; hb = 1; end
      else if (mH >= blk - 4 && mH < blk) begin isCode = 1; idx = mH - (blk - 4); hb = 0; end
      if (isCode && embedEn) begin
        if (idx == 0) begin eD = 'hFF; tD = "R4"; end
        else if (idx < 3) begin eD = 0; tD = "R4"; end
        else begin
          eD = {1'b1, f, v, hb, v ^ hb, f ^ hb, f ^ v, f ^ v ^ hb};
          tD = sys625 ? "R6" : "R5";
        end
      end else if (mH >= blk) begin
        eD = vidData; tD = "R7";
      end else begin
        eD = (mH % 2) ? 'h10 : 'h80;
        tD = isCode ? "R9" : "R8";
      end
      eHd = stdSync ? int'(mH < blk) : int'(mH < HDT);
      tHd = stdSync ? "R10" : "R11";
      hl = (mLine - 1) * 2 + ((mH >= lc / 2) ? 1 : 0);
      w  = (sys625 && vdShort) ? 5 : 6;
      fs = sys625 ? 625 : 525;
      inWin = (hl < w) || (hl >= fs && hl < fs + w);
      eVd = stdSync ? int'(v) : int'(inWin);
      tVd = stdSync ? "R10" : "R13";
      // advance
      if (mH == lc - 1) begin
        mH = 0;
        mLine = (mLine == (sys625 ? 625 : 525)) ? 1 : mLine + 1;
      end else mH++;
      live = 1;
    end
  end

  // Per-clock comparison and per-line measurements
  bit prevHd = 0;
  int lastRise = -1, takeCnt = 0;
  always @(negedge clk) begin
    if (!done) vidData <= 8'(1 + ((cyc * 37) % 254));
    if (live && !rst && !done) begin
      chk(tD, "dataOut", dataOut, eD);
      chk(tHd, "hdOut", hdOut, eHd);
      chk(tVd, "vdOut", vdOut, eVd);
      chk("R7", "vidTake", vidTake, int'(mH >= blkOf(sys625)));
      if (hdOut && !prevHd) begin
        if (lastRise >= 0) begin
          chk("R1", "line clocks", cyc - lastRise, lineOf(sys625));
          chk("R3", "active bytes per line", takeCnt, 2 * A);
        end
        lastRise = cyc; takeCnt = 0;
      end
      if (vidTake) takeCnt++;
      prevHd = hdOut;
    end else if (rst) begin
      prevHd = 0; lastRise = -1; takeCnt = 0;
    end
  end

  task automatic runMode(input logic s, input logic st, input logic em, input logic sh, input int n);
    @(negedge clk);
    rst = 1; sys625 = s; stdSync = st; embedEn = em; vdShort = sh;
    repeat (3) @(negedge clk);
    chk("R2", "reset dataOut", dataOut, 'h10);
    chk("R2", "reset hd/vd", {hdOut, vdOut}, 0);
    rst = 0;
    @(negedge clk);
    chk("R2", "first byte after reset", dataOut, em ? 'hFF : 'h80);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    runMode(1'b0, 1'b1, 1'b1, 1'b0, 21100); // 525, standard sync, R5 R10
    runMode(1'b0, 1'b0, 1'b1, 1'b1, 21100); // 525, through, vdShort ignored R12 R13
    runMode(1'b1, 1'b0, 1'b1, 1'b0, 27600); // 625, through 3.0 lines R6 R12
    runMode(1'b1, 1'b0, 1'b1, 1'b1, 27600); // 625, through 2.5 lines R13
    runMode(1'b1, 1'b1, 1'b0, 1'b0, 27600); // 625, codes off R9
    runMode(1'b0, 1'b1, 1'b0, 1'b0, 4000);  // 525, codes off R9
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 190000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule